// File: doc/BRIEF.md
# Descriptor Table Register Unit

This unit holds the four registers that locate the system tables: the global table, the interrupt table, the local table and the current task-state segment. Each register has a 24-bit real base address and a 16-bit limit, which is the largest byte offset allowed into the table. The local-table and task registers also keep the 16-bit selector they were loaded from. A microsequencer drives the unit with one command at a time and reads the base and limit values directly from output ports.

The global and interrupt registers are loaded from a 6-byte memory image. The image arrives over a serial port whose width is a parameter: 8 bits gives six beats and 16 bits gives three. The local-table and task registers are loaded from a selector together with the 48-bit descriptor that the sequencer has already fetched from the global table. The unit checks the privilege level, the location and range of the selector, and the busy flag of the task descriptor. When a task load succeeds, it asks the sequencer to write back the descriptor's access byte with the busy flag set. Store commands return a selector.

A separate check port tests whether an 8-byte table entry at a given offset lies within the limit of a chosen table.

Top module: `dtreg_unit`

## Requirements
- R1: After reset every base, limit and selector output is zero, and `done`, `fault13`, `wb_valid` and `chk_viol` are low.
- R2: A global-table or interrupt-table load (op 0 or 1) at CPL 0 takes the image little-endian over 48/LOAD_W beats. Bytes 0 and 1 are the limit, bytes 2 to 4 are the base, and byte 5 is ignored. The register updates and `done` pulses in the cycle after the final beat.
- R3: Ops 0 to 3 issued with CPL other than 0 pulse `fault13` one cycle later. No register changes and `done` stays low.
- R4: For op 2 (local table) and op 3 (task), a selector that is not null and has its table bit (bit 2) set faults. So does one whose bits [15:3] times 8 plus 7 exceed the global limit.
- R5: A valid op 2 loads the local selector from `cmd_sel`, the base from `desc_word[39:16]` and the limit from `desc_word[15:0]`. It then pulses `done`.
- R6: An op 2 whose selector bits [15:2] are zero is null. It skips the range check, stores the selector and clears the local base and limit.
- R7: An op 3 faults when the selector is null or when the busy flag (`desc_word[41]`, bit 1 of the access byte) is already set.
- R8: A valid op 3 loads the task register and pulses `done`. It also raises `wb_valid` for exactly one cycle, with `wb_addr` equal to the global base plus index×8+5 and `wb_acc` equal to the access byte with bit 1 set. No other register changes.
- R9: Op 4 returns the local selector and op 5 returns the task selector on `st_sel`, with `done`, at any CPL and without a fault.
- R10: One cycle after `chk_valid`, `chk_viol` is high exactly when `chk_off`+7 (17-bit sum) exceeds the limit of the table selected by `chk_tbl`: 0 global, 1 interrupt, 2 local, 3 task.
- R11: Commands that arrive while an image is being captured are ignored. They produce no `done`, no fault and no register change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | 0 load global, 1 load interrupt, 2 load local, 3 load task, 4 store local, 5 store task |
| cmd_cpl | input | 2 | Current privilege level |
| cmd_sel | input | 16 | Selector operand |
| desc_word | input | 48 | Fetched descriptor: limit [15:0], base [39:16], access [47:40] |
| img_valid | input | 1 | Image beat strobe |
| img_data | input | LOAD_W | Image beat, lowest byte first |
| chk_valid | input | 1 | Limit check request |
| chk_tbl | input | 2 | Table to check against |
| chk_off | input | 16 | Entry offset to check |
| done | output | 1 | Command completed |
| fault13 | output | 1 | Protection fault |
| st_sel | output | 16 | Stored selector |
| wb_valid | output | 1 | Busy-flag write-back request |
| wb_addr | output | 24 | Access byte address |
| wb_acc | output | 8 | Access byte to write |
| chk_viol | output | 1 | Limit violation |
| gdt_base | output | 24 | Global table base |
| gdt_lim | output | 16 | Global table limit |
| idt_base | output | 24 | Interrupt table base |
| idt_lim | output | 16 | Interrupt table limit |
| ldt_sel | output | 16 | Local table selector |
| ldt_base | output | 24 | Local table base |
| ldt_lim | output | 16 | Local table limit |
| tr_sel | output | 16 | Task selector |
| tr_base | output | 24 | Task segment base |
| tr_lim | output | 16 | Task segment limit |

## Verification
The bench sweeps the selector index across both sides of the global limit, with the table bit in both states. A design that compared the index itself rather than index×8+7 would accept an entry that overruns the table by one. It sweeps every CPL on every privileged op, so a missing privilege gate shows up as a register change. Task loads are tried with the busy flag set and clear, and the write-back address and access byte are checked. An adder that dropped the +5 offset, or a design that did not set the flag, gives a wrong address or byte.

Limit checks walk offsets across each limit and include a limit of 0xFFFF. A 16-bit sum would wrap there and report no violation. A command injected in the middle of an image load exposes a unit that lets it through.

// File: rtl/dtreg_pkg.sv
// Package: shared widths, op codes, table indices and register type for the
// descriptor table register unit. Assumes a 48-bit descriptor layout of
// limit, base, access byte from the low end.
package dtreg_pkg;
    parameter int BASE_W = 24;
    parameter int LIM_W  = 16;
    parameter int SEL_W  = 16;
    parameter int ACC_W  = 8;
    localparam int DESC_W   = LIM_W + BASE_W + ACC_W;
    localparam int IMG_W    = 48;
    localparam int IMG_USED = LIM_W + BASE_W;
    localparam int NTBL     = 4;
    localparam int BUSY_BIT = 1;
    localparam int ACC_OFS  = 5;
    localparam int ENT_SH   = 3;

    typedef enum logic [2:0] {
        OP_LGDT = 3'd0,
        OP_LIDT = 3'd1,
        OP_LLDT = 3'd2,
        OP_LTR  = 3'd3,
        OP_SLDT = 3'd4,
        OP_STR  = 3'd5
    } dt_op_e;

    typedef enum logic [1:0] {
        T_GDT = 2'd0,
        T_IDT = 2'd1,
        T_LDT = 2'd2,
        T_TR  = 2'd3
    } dt_tbl_e;

    typedef struct packed {
        logic [BASE_W-1:0] base;
        logic [LIM_W-1:0]  lim;
    } tbl_reg_t;
endpackage

// File: rtl/dtreg_img_asm.sv
// Module: collects the serial 6-byte table image into a limit+base word.
// Assumes LOAD_W is 8 or 16. The final beat is used directly, without a
// register stage, so the image is complete in the cycle of the last beat.
module dtreg_img_asm
    import dtreg_pkg::*;
#(
    parameter int LOAD_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic                beat_valid,
    input  logic [LOAD_W-1:0]   beat_data,
    output logic                active,
    output logic                img_done,
    output logic [IMG_USED-1:0] img_out
);
    localparam int BEATS  = IMG_W / LOAD_W;
    localparam int CW     = $clog2(BEATS);
    localparam int HELD_W = IMG_W - LOAD_W;

    logic [CW-1:0]     cnt;
    logic [HELD_W-1:0] held;
    logic              last_beat;

    assign last_beat = active && beat_valid && (cnt == CW'(BEATS - 1));
    assign img_done  = last_beat;

    // Tracks capture state and counts accepted beats
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            cnt    <= '0;
        end else if (start && !active) begin
            active <= 1'b1;
            cnt    <= '0;
        end else if (last_beat) begin
            active <= 1'b0;
            cnt    <= '0;
        end else if (active && beat_valid) begin
            cnt <= cnt + 1'b1;
        end
    end

    // One holding slot per beat except the last
    for (genvar b = 0; b < BEATS - 1; b++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n)
                held[b*LOAD_W +: LOAD_W] <= '0;
            else if (active && beat_valid && cnt == CW'(b))
                held[b*LOAD_W +: LOAD_W] <= beat_data;
        end
    end

    if (LOAD_W == 8) begin : g_byte
        assign img_out = held;
    end else begin : g_word
        logic unused_pad;
        assign unused_pad = ^beat_data[LOAD_W-1:8];
        assign img_out = {beat_data[7:0], held};
    end

    AST_IMG_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < CW'(BEATS)); // R2
    AST_IMG_IDLE_CNT: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> cnt == '0); // R2
endmodule

// File: rtl/dtreg_selchk.sv
// Module: checks a selector-based load for privilege, table bit, range
// against the global limit, null selector and busy flag. Purely
// combinational. Assumes the descriptor has already been fetched.
module dtreg_selchk
    import dtreg_pkg::*;
(
    input  logic [SEL_W-1:2] sel_hi,
    input  logic [1:0]       cpl,
    input  logic [LIM_W-1:0] gdt_lim,
    input  logic             busy,
    input  logic             is_ltr,
    output logic             is_null,
    output logic             bad
);
    logic             ti;
    logic [LIM_W-1:0] ent_end;
    logic             over;

    assign ti      = sel_hi[2];
    assign ent_end = {sel_hi[SEL_W-1:ENT_SH], {ENT_SH{1'b1}}};
    assign over    = ent_end > gdt_lim;
    assign is_null = (sel_hi == '0);

    // Combines every reason to reject the load
    always_comb begin
        bad = 1'b0;
        if (cpl != 2'd0)
            bad = 1'b1;
        else if (is_null)
            bad = is_ltr;
        else if (ti || over)
            bad = 1'b1;
        else if (is_ltr && busy)
            bad = 1'b1;
    end

    always_comb begin
        AST_NULL_LLDT_OK: assert (!(is_null && !is_ltr && cpl == 2'd0 && bad)); // R6
    end
endmodule

// File: rtl/dtreg_limchk.sv
// Module: registered check that an 8-byte entry at an offset fits within
// the selected table's limit. The sum is one bit wider so it cannot wrap.
module dtreg_limchk
    import dtreg_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       chk_valid,
    input  logic [1:0]                 chk_tbl,
    input  logic [LIM_W-1:0]           chk_off,
    input  logic [NTBL-1:0][LIM_W-1:0] lims,
    output logic                       viol
);
    logic [LIM_W:0] last_byte;
    logic [LIM_W:0] sel_lim;

    assign last_byte = {1'b0, chk_off} + (LIM_W+1)'((1 << ENT_SH) - 1);
    assign sel_lim   = {1'b0, lims[chk_tbl]};

    // Registers the comparison result for one cycle
    always_ff @(posedge clk) begin
        if (!rst_n) viol <= 1'b0;
        else        viol <= chk_valid && (last_byte > sel_lim);
    end

    AST_VIOL_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        viol |-> $past(chk_valid)); // R10
endmodule

// File: rtl/dtreg_unit.sv
// Module: register file and command control for the global, interrupt,
// local-table and task registers. Assumes one command at a time from a
// sequencer that fetches descriptors itself and carries out write-back.
module dtreg_unit
    import dtreg_pkg::*;
#(
    parameter int LOAD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [1:0]        cmd_cpl,
    input  logic [15:0]       cmd_sel,
    input  logic [47:0]       desc_word,
    input  logic              img_valid,
    input  logic [LOAD_W-1:0] img_data,
    input  logic              chk_valid,
    input  logic [1:0]        chk_tbl,
    input  logic [15:0]       chk_off,
    output logic              done,
    output logic              fault13,
    output logic [15:0]       st_sel,
    output logic              wb_valid,
    output logic [23:0]       wb_addr,
    output logic [7:0]        wb_acc,
    output logic              chk_viol,
    output logic [23:0]       gdt_base,
    output logic [15:0]       gdt_lim,
    output logic [23:0]       idt_base,
    output logic [15:0]       idt_lim,
    output logic [15:0]       ldt_sel,
    output logic [23:0]       ldt_base,
    output logic [15:0]       ldt_lim,
    output logic [15:0]       tr_sel,
    output logic [23:0]       tr_base,
    output logic [15:0]       tr_lim
);
    dt_op_e                     op;
    logic                       cap_busy;
    logic                       img_done;
    logic [IMG_USED-1:0]        img_out;
    dt_tbl_e                    cap_tbl;
    logic                       accept;
    logic                       is_tbl_load;
    logic                       is_sel_load;
    logic                       sc_null;
    logic                       sc_bad;
    logic                       start_cap;
    logic                       fault_now;
    logic                       lldt_ok;
    logic                       ltr_ok;
    logic                       store_now;
    logic [NTBL-1:0]            wr_en;
    tbl_reg_t [NTBL-1:0]        wr_val;
    tbl_reg_t [NTBL-1:0]        rd;
    logic [NTBL-1:0][LIM_W-1:0] lims;
    logic [LIM_W-1:0]           d_lim;
    logic [BASE_W-1:0]          d_base;
    logic [ACC_W-1:0]           d_acc;
    logic [BASE_W-1:0]          ent_ofs;

    assign op          = dt_op_e'(cmd_op);
    assign accept      = cmd_valid && !cap_busy;
    assign is_tbl_load = (op == OP_LGDT) || (op == OP_LIDT);
    assign is_sel_load = (op == OP_LLDT) || (op == OP_LTR);
    assign d_lim       = desc_word[LIM_W-1:0];
    assign d_base      = desc_word[LIM_W +: BASE_W];
    assign d_acc       = desc_word[DESC_W-1 -: ACC_W];
    assign ent_ofs     = BASE_W'({cmd_sel[SEL_W-1:ENT_SH], 3'(ACC_OFS)});

    dtreg_img_asm #(.LOAD_W(LOAD_W)) u_img (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start_cap),
        .beat_valid (img_valid),
        .beat_data  (img_data),
        .active     (cap_busy),
        .img_done   (img_done),
        .img_out    (img_out)
    );

    dtreg_selchk u_sel (
        .sel_hi  (cmd_sel[SEL_W-1:2]),
        .cpl     (cmd_cpl),
        .gdt_lim (rd[T_GDT].lim),
        .busy    (d_acc[BUSY_BIT]),
        .is_ltr  (op == OP_LTR),
        .is_null (sc_null),
        .bad     (sc_bad)
    );

    dtreg_limchk u_lim (
        .clk       (clk),
        .rst_n     (rst_n),
        .chk_valid (chk_valid),
        .chk_tbl   (chk_tbl),
        .chk_off   (chk_off),
        .lims      (lims),
        .viol      (chk_viol)
    );

    // Decodes the accepted command into its outcome
    always_comb begin
        start_cap = accept && is_tbl_load && (cmd_cpl == 2'd0);
        fault_now = accept && ((is_tbl_load && cmd_cpl != 2'd0) ||
                               (is_sel_load && sc_bad));
        lldt_ok   = accept && (op == OP_LLDT) && !sc_bad;
        ltr_ok    = accept && (op == OP_LTR) && !sc_bad;
        store_now = accept && ((op == OP_SLDT) || (op == OP_STR));
    end

    // Selects write enable and write value for each table register
    always_comb begin
        wr_en  = '0;
        wr_val = '0;
        wr_val[T_GDT] = '{base: img_out[IMG_USED-1:LIM_W], lim: img_out[LIM_W-1:0]};
        wr_val[T_IDT] = wr_val[T_GDT];
        wr_val[T_LDT] = sc_null ? '0 : '{base: d_base, lim: d_lim};
        wr_val[T_TR]  = '{base: d_base, lim: d_lim};
        wr_en[T_GDT]  = img_done && (cap_tbl == T_GDT);
        wr_en[T_IDT]  = img_done && (cap_tbl == T_IDT);
        wr_en[T_LDT]  = lldt_ok;
        wr_en[T_TR]   = ltr_ok;
    end

    // One register per table, loaded only by its own write enable
    for (genvar t = 0; t < NTBL; t++) begin : g_tbl
        tbl_reg_t q;
        always_ff @(posedge clk) begin
            if (!rst_n)        q <= '0;
            else if (wr_en[t]) q <= wr_val[t];
        end
        assign rd[t]   = q;
        assign lims[t] = q.lim;
    end

    // Holds selectors, capture target and response pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done     <= 1'b0;
            fault13  <= 1'b0;
            wb_valid <= 1'b0;
            wb_addr  <= '0;
            wb_acc   <= '0;
            st_sel   <= '0;
            ldt_sel  <= '0;
            tr_sel   <= '0;
            cap_tbl  <= T_GDT;
        end else begin
            done     <= img_done || lldt_ok || ltr_ok || store_now;
            fault13  <= fault_now;
            wb_valid <= ltr_ok;
            if (start_cap)
                cap_tbl <= (op == OP_LIDT) ? T_IDT : T_GDT;
            if (lldt_ok)
                ldt_sel <= cmd_sel;
            if (ltr_ok) begin
                tr_sel  <= cmd_sel;
                wb_addr <= rd[T_GDT].base + ent_ofs;
                wb_acc  <= d_acc | ACC_W'(1 << BUSY_BIT);
            end
            if (store_now)
                st_sel <= (op == OP_SLDT) ? ldt_sel : tr_sel;
        end
    end

    assign gdt_base = rd[T_GDT].base;
    assign gdt_lim  = rd[T_GDT].lim;
    assign idt_base = rd[T_IDT].base;
    assign idt_lim  = rd[T_IDT].lim;
    assign ldt_base = rd[T_LDT].base;
    assign ldt_lim  = rd[T_LDT].lim;
    assign tr_base  = rd[T_TR].base;
    assign tr_lim   = rd[T_TR].lim;

    AST_FAULT_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(fault13 && done)); // R3
    AST_FAULT_KEEPS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        fault13 |-> (tr_sel == $past(tr_sel)) && (ldt_sel == $past(ldt_sel))); // R3
    AST_WB_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |=> !wb_valid); // R8
    AST_WB_GDT_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> done && !tr_sel[2] && wb_acc[BUSY_BIT]); // R4
    AST_CAP_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_busy && !img_done) |=> !done && !fault13); // R11
endmodule

// File: tb/sim_dtreg_unit.sv
module sim_dtreg_unit;
    localparam int W     = 8;
    localparam int BEATS = 48 / W;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic [2:0]    cmd_op = '0;
    logic [1:0]    cmd_cpl = '0;
    logic [15:0]   cmd_sel = '0;
    logic [47:0]   desc_word = '0;
    logic          img_valid = 1'b0;
    logic [W-1:0]  img_data = '0;
    logic          chk_valid = 1'b0;
    logic [1:0]    chk_tbl = '0;
    logic [15:0]   chk_off = '0;
    logic          done, fault13, wb_valid, chk_viol;
    logic [15:0]   st_sel, gdt_lim, idt_lim, ldt_sel, ldt_lim, tr_sel, tr_lim;
    logic [23:0]   wb_addr, gdt_base, idt_base, ldt_base, tr_base;
    logic [7:0]    wb_acc;

    int n_chk = 0;
    int n_fail = 0;

    // model state
    logic [23:0] m_gb = '0, m_ib = '0, m_lb = '0, m_tb = '0;
    logic [15:0] m_gl = '0, m_il = '0, m_ll = '0, m_tl = '0, m_ls = '0, m_ts = '0;

    always #4 clk = ~clk;

    dtreg_unit #(.LOAD_W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_cpl(cmd_cpl), .cmd_sel(cmd_sel), .desc_word(desc_word),
        .img_valid(img_valid), .img_data(img_data), .chk_valid(chk_valid),
        .chk_tbl(chk_tbl), .chk_off(chk_off), .done(done), .fault13(fault13),
        .st_sel(st_sel), .wb_valid(wb_valid), .wb_addr(wb_addr), .wb_acc(wb_acc),
        .chk_viol(chk_viol), .gdt_base(gdt_base), .gdt_lim(gdt_lim),
        .idt_base(idt_base), .idt_lim(idt_lim), .ldt_sel(ldt_sel),
        .ldt_base(ldt_base), .ldt_lim(ldt_lim), .tr_sel(tr_sel),
        .tr_base(tr_base), .tr_lim(tr_lim)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk_regs(input string req);
        chk(req, {gdt_base, gdt_lim, idt_base}, {m_gb, m_gl, m_ib});
        chk(req, {idt_lim, ldt_sel, ldt_base, ldt_lim}, {m_il, m_ls, m_lb, m_ll});
        chk(req, {tr_sel, tr_base, tr_lim}, {m_ts, m_tb, m_tl});
    endtask

    // one command, outputs sampled one cycle later
    task automatic issue(input logic [2:0] op, input logic [1:0] cpl,
                         input logic [15:0] sel, input logic [47:0] desc);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_cpl = cpl; cmd_sel = sel; desc_word = desc;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic load_img(input logic [2:0] op, input logic [15:0] lim,
                            input logic [23:0] base, input logic [7:0] junk,
                            input bit intrude);
        logic [47:0] img;
        img = {junk, base, lim};
        issue(op, 2'd0, 16'h0, 48'h0);
        chk("R2 no done on start", {done, fault13}, 2'b00);
        for (int k = 0; k < BEATS; k++) begin
            img_valid = 1'b1;
            img_data = img[k*W +: W];
            if (intrude && k == 1) begin
                cmd_valid = 1'b1; cmd_op = 3'd3; cmd_cpl = 2'd0;
                cmd_sel = 16'h0008; desc_word = {8'h81, 24'h00BEEF, 16'h002B};
            end
            @(negedge clk);
            img_valid = 1'b0;
            cmd_valid = 1'b0;
            if (intrude && k < BEATS - 1)
                chk("R11 ignored cmd in capture", {done, fault13, wb_valid}, 3'b000);
        end
        chk("R2 done after last beat", {done, fault13}, 2'b10);
        if (op == 3'd0) begin m_gl = lim; m_gb = base; end
        else begin m_il = lim; m_ib = base; end
        chk_regs("R2 image load");
    endtask

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk_regs("R1 reset regs");
        chk("R1 reset pulses", {done, fault13, wb_valid, chk_viol}, 4'b0000);

        // R2 image loads
        load_img(3'd1, 16'h07FF, 24'hABCDEF, 8'h5A, 1'b0);
        load_img(3'd0, 16'h1234, 24'h00FFEE, 8'hFF, 1'b0);
        load_img(3'd0, 16'h003F, 24'h123456, 8'hA5, 1'b0);

        // R3 privilege sweep
        for (int c = 1; c < 4; c++) begin
            for (int o = 0; o < 4; o++) begin
                issue(3'(o), 2'(c), 16'h0008, {8'h81, 24'h111111, 16'h00FF});
                chk("R3 fault at cpl>0", {done, fault13, wb_valid}, 3'b010);
                chk_regs("R3 regs unchanged");
            end
        end

        // R11 intrusion during capture
        load_img(3'd0, 16'h003F, 24'h123456, 8'h00, 1'b1);

        // R4 R5 R6 local-table selector sweep
        for (int idx = 0; idx < 10; idx++) begin
            for (int ti = 0; ti < 2; ti++) begin
                logic [15:0] s;
                logic [47:0] d;
                bit nul, bad;
                s = {13'(idx), 1'(ti), 2'b01};
                d = {8'h82, 24'(idx * 24'h1000 + 24'h10), 16'(idx * 16 + 15)};
                nul = (idx == 0) && (ti == 0);
                bad = !nul && ((ti == 1) || (idx * 8 + 7 > 16'h3F));
                issue(3'd2, 2'd0, s, d);
                if (bad) begin
                    chk("R4 bad selector faults", {done, fault13}, 2'b01);
                end else begin
                    chk("R5 R6 local load done", {done, fault13}, 2'b10);
                    m_ls = s;
                    m_lb = nul ? 24'h0 : d[39:16];
                    m_ll = nul ? 16'h0 : d[15:0];
                end
                chk_regs("R4 R5 R6 local regs");
            end
        end

        // R7 R8 task load sweep
        for (int idx = 0; idx < 10; idx++) begin
            for (int bz = 0; bz < 2; bz++) begin
                logic [15:0] s;
                logic [47:0] d;
                logic [7:0] acc;
                bit bad;
                s = {13'(idx), 1'b0, 2'b00};
                acc = 8'h81 | 8'(bz << 1);
                d = {acc, 24'(24'h200000 + idx * 24'h100), 16'h002B};
                bad = (idx == 0) || (bz == 1) || (idx * 8 + 7 > 16'h3F);
                issue(3'd3, 2'd0, s, d);
                if (bad) begin
                    chk("R7 task load faults", {done, fault13, wb_valid}, 3'b010);
                end else begin
                    chk("R8 task load done", {done, fault13, wb_valid}, 3'b101);
                    chk("R8 write-back addr", wb_addr, 24'h123456 + 24'(idx * 8 + 5));
                    chk("R8 write-back acc", wb_acc, acc | 8'h02);
                    m_ts = s; m_tb = d[39:16]; m_tl = d[15:0];
                end
                chk_regs("R7 R8 task regs");
                @(negedge clk);
                chk("R8 single write-back pulse", {wb_valid, done}, 2'b00);
            end
        end

        // R9 stores at every CPL
        for (int c = 0; c < 4; c++) begin
            issue(3'd4, 2'(c), 16'h0, 48'h0);
            chk("R9 store local", {done, fault13, st_sel}, {2'b10, m_ls});
            issue(3'd5, 2'(c), 16'h0, 48'h0);
            chk("R9 store task", {done, fault13, st_sel}, {2'b10, m_ts});
        end

        // R10 limit checks across each table
        for (int t = 0; t < 4; t++) begin
            logic [15:0] l;
            l = (t == 0) ? m_gl : (t == 1) ? m_il : (t == 2) ? m_ll : m_tl;
            for (int dlt = -9; dlt < 3; dlt++) begin
                logic [15:0] o;
                o = 16'(int'(l) + dlt);
                if (int'(l) + dlt < 0) continue;
                @(negedge clk);
                chk_valid = 1'b1; chk_tbl = 2'(t); chk_off = o;
                @(negedge clk);
                chk_valid = 1'b0;
                chk("R10 limit check", chk_viol, (17'(o) + 17'd7) > 17'(l));
            end
        end
        load_img(3'd0, 16'hFFFF, 24'h000100, 8'h11, 1'b0);
        for (int o = 16'hFFF6; o <= 16'hFFFF; o++) begin
            @(negedge clk);
            chk_valid = 1'b1; chk_tbl = 2'd0; chk_off = 16'(o);
            @(negedge clk);
            chk_valid = 1'b0;
            chk("R10 wide limit", chk_viol, (o + 7) > 16'hFFFF);
        end
        @(negedge clk);
        chk("R10 no request no flag", chk_viol, 1'b0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule